// File: doc/BRIEF.md
# Serial Port Status Register

This block holds the status byte of a combined UART/SPI serial unit. The transmit and receive datapaths report events to it as single-cycle strobes: the transmit buffer was written, the transmit buffer handed its byte to the shifter, the shifter finished a frame, a received frame arrived together with its error indications, and the receive buffer was read. The block also watches the receive pin and a low-power stop indication. From these it keeps an 8-bit status byte that a CPU can read at any time and four interrupt requests, each gated by its own enable input.

The flags follow different clear rules. Receive errors stay until the receive buffer is read. The transmit-complete flag clears when its interrupt is acknowledged. The wake flag is cleared only by a CPU write. A write-one local-reset bit sends a one-cycle reset pulse to the rest of the serial unit and clears itself. A receive overrun also stops further frames from being loaded until the buffer is read.

Three small state machines carry the behaviour:
- **Transmit buffer machine.** States `TXB_EMPTY` and `TXB_FULL`. The transition EMPTY→FULL happens on a buffer write. The transition FULL→EMPTY happens on a buffer hand-off that has no write in the same cycle.
- **Receive buffer machine.** States `RXB_EMPTY`, `RXB_FULL` and `RXB_OVERRUN`. EMPTY→FULL happens on a frame. FULL→EMPTY happens on a read. FULL→OVERRUN happens on a frame without a read. In FULL, a read and a frame in the same cycle reload the buffer and the machine stays in FULL. OVERRUN→EMPTY happens on a read.
- **Local-reset machine.** States `LR_IDLE` and `LR_PULSE`. IDLE→PULSE happens on a write with the reset bit set. PULSE→IDLE happens unconditionally.

Top module: `sstat_reg`

## Requirements
- R1: After reset the status byte is 0x80 and `srst_o` is 0. The byte layout is bit7 transmit-buffer-empty, bit6 transmit-complete, bit5 receive-complete, bit4 wake, bit3 local-reset, bit2 overrun, bit1 frame-error, bit0 parity-error.
- R2: Bit7 reads 0 one cycle after `tx_buf_wr` and reads 1 again one cycle after `tx_buf_take` without a simultaneous write.
- R3: Bit6 sets one cycle after `tx_shift_done` while bit7 is 1 and no write arrives in that cycle. If bit7 is 0, a shift-done strobe does not set it. It holds until `txc_ack`, which clears it. A set and an acknowledge in the same cycle leave it set.
- R4: Bit5 sets one cycle after `rx_frame_done` and clears one cycle after `rx_buf_rd`. A read and a frame in the same cycle leave it set with the new frame's errors.
- R5: When a frame loads, bit1 takes `rx_frame_fe` if `uart_mode` is 1. Bit0 takes `rx_frame_pe` only if both `uart_mode` and `par_en` are 1. Both clear on a buffer read.
- R6: A frame arriving while bit5 is set and no read occurs sets bit2. While bit2 is set, frames are discarded and bits 1 and 0 keep their values. A read clears bit2.
- R7: Bit4 sets when `uart_mode` and `stop_mode` are 1 and `rx_pin` is 0. It stays set until a CPU write with bit4 = 0. Writing 1 to bit4 has no effect. A set and a clear in the same cycle leave it set.
- R8: A CPU write with bit3 = 1 drives `srst_o` and status bit3 high for exactly the next cycle. In the cycle after that, every bit except bit4 returns to its R1 value.
- R9: CPU writes to bits 7, 6, 5, 2, 1 and 0 have no effect on the status byte.
- R10: Each `irq_*` output equals its flag (bit7, bit6, bit5 or bit4) ANDed with the matching `ie_*` input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| uart_mode | input | 1 | 1 = asynchronous (UART) operation |
| par_en | input | 1 | Parity checking enabled |
| stop_mode | input | 1 | System is in low-power stop |
| rx_pin | input | 1 | Receive pin level |
| tx_buf_wr | input | 1 | Strobe: transmit buffer written |
| tx_buf_take | input | 1 | Strobe: transmit buffer moved to shifter |
| tx_shift_done | input | 1 | Strobe: frame fully shifted out |
| txc_ack | input | 1 | Transmit-complete interrupt serviced |
| rx_frame_done | input | 1 | Strobe: received frame ready |
| rx_frame_fe | input | 1 | Frame's first stop bit sampled 0 |
| rx_frame_pe | input | 1 | Frame failed parity |
| rx_buf_rd | input | 1 | Strobe: receive buffer read |
| cpu_wr | input | 1 | CPU write to status byte |
| cpu_wdata | input | 8 | CPU write data |
| ie_dre | input | 1 | Enable for transmit-buffer-empty request |
| ie_txc | input | 1 | Enable for transmit-complete request |
| ie_rxc | input | 1 | Enable for receive-complete request |
| ie_wake | input | 1 | Enable for wake request |
| stat_o | output | 8 | Status byte |
| srst_o | output | 1 | One-cycle local reset for the serial unit |
| irq_dre | output | 1 | Transmit-buffer-empty request |
| irq_txc | output | 1 | Transmit-complete request |
| irq_rxc | output | 1 | Receive-complete request |
| irq_wake | output | 1 | Wake request |

## Verification
On the transmit side, shift-done is applied in three cases: with the buffer empty, with the buffer full, and together with an acknowledge. These three cases separate the set condition from the clear priority. On the receive side, frames arrive with an empty buffer, with a full buffer, while in overrun, and in the same cycle as a read. Each is given different fault-bit combinations, so a discarded frame cannot be mistaken for a loaded one, and the effect of the mode and parity gating shows in the fault bits. For the wake flag and the local reset, wake events are placed against zero-writes, one-writes and a reset write that keeps bit4 = 1. This shows which flags each clear source reaches and that the reset pulse lasts one cycle.

// File: rtl/sstat_pkg.sv
package sstat_pkg;
    localparam int STAT_W = 8;
    localparam int B_DRE  = 7;
    localparam int B_TXC  = 6;
    localparam int B_RXC  = 5;
    localparam int B_WAKE = 4;
    localparam int B_LRST = 3;
    localparam int B_DOR  = 2;
    localparam int B_FE   = 1;
    localparam int B_PE   = 0;
    localparam logic [STAT_W-1:0] STAT_RST  = STAT_W'(1) << B_DRE;
    localparam logic [STAT_W-1:0] WAKE_MASK = STAT_W'(1) << B_WAKE;

    typedef enum logic {TXB_EMPTY, TXB_FULL} txb_state_e;
    typedef enum logic [1:0] {RXB_EMPTY, RXB_FULL, RXB_OVERRUN} rxb_state_e;
    typedef enum logic {LR_IDLE, LR_PULSE} lr_state_e;
endpackage

// File: rtl/sstat_tx.sv
module sstat_tx
    import sstat_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic soft_clr,
    input  logic buf_wr,
    input  logic buf_take,
    input  logic shift_done,
    input  logic txc_ack,
    output logic dre,
    output logic txc
);
    txb_state_e st_q, st_d;
    logic       txc_set;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        st_q <= TXB_EMPTY;
        else if (soft_clr) st_q <= TXB_EMPTY;
        else               st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            TXB_EMPTY: if (buf_wr) st_d = TXB_FULL;
            TXB_FULL:  if (buf_take && !buf_wr) st_d = TXB_EMPTY;
            default:   st_d = TXB_EMPTY;
        endcase
    end

    always_comb begin
        dre     = (st_q == TXB_EMPTY);
        txc_set = shift_done && (st_q == TXB_EMPTY) && !buf_wr;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        txc <= 1'b0;
        else if (soft_clr) txc <= 1'b0;
        else if (txc_set)  txc <= 1'b1;
        else if (txc_ack)  txc <= 1'b0;
    end

    AST_DRE_DROPS_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        buf_wr && !soft_clr |=> !dre); // R2
    AST_TXC_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        shift_done && dre && !buf_wr && !soft_clr |=> txc); // R3
    AST_TXC_NO_SET_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        !txc && !dre |=> !txc); // R3
    AST_TXC_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        txc_ack && !(shift_done && dre) && !soft_clr |=> !txc); // R3
endmodule

// File: rtl/sstat_rx.sv
module sstat_rx
    import sstat_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic soft_clr,
    input  logic uart_mode,
    input  logic par_en,
    input  logic frame_done,
    input  logic frame_fe,
    input  logic frame_pe,
    input  logic buf_rd,
    output logic rxc,
    output logic dor,
    output logic fe,
    output logic pe
);
    rxb_state_e st_q, st_d;
    logic       load;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        st_q <= RXB_EMPTY;
        else if (soft_clr) st_q <= RXB_EMPTY;
        else               st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        load = 1'b0;
        unique case (st_q)
            RXB_EMPTY: begin
                if (frame_done) begin
                    st_d = RXB_FULL;
                    load = 1'b1;
                end
            end
            RXB_FULL: begin
                if (buf_rd && frame_done) load = 1'b1;
                else if (buf_rd)          st_d = RXB_EMPTY;
                else if (frame_done)      st_d = RXB_OVERRUN;
            end
            RXB_OVERRUN: begin
                if (buf_rd) st_d = RXB_EMPTY;
            end
            default: st_d = RXB_EMPTY;
        endcase
    end

    always_comb begin
        rxc = (st_q != RXB_EMPTY);
        dor = (st_q == RXB_OVERRUN);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fe <= 1'b0;
            pe <= 1'b0;
        end else if (soft_clr) begin
            fe <= 1'b0;
            pe <= 1'b0;
        end else if (load) begin
            fe <= uart_mode && frame_fe;
            pe <= uart_mode && par_en && frame_pe;
        end else if (buf_rd) begin
            fe <= 1'b0;
            pe <= 1'b0;
        end
    end

    AST_RX_FRAME_FILLS: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done && !rxc && !soft_clr |=> rxc && !dor); // R4
    AST_RX_READ_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        buf_rd && !frame_done && !soft_clr |=> !rxc && !dor && !fe && !pe); // R4
    AST_RX_ERR_NEEDS_UART: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done && !rxc && !uart_mode && !soft_clr |=> !fe && !pe); // R5
    AST_OVR_FREEZES_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        dor && !buf_rd && !soft_clr |=> dor && $stable(fe) && $stable(pe)); // R6
    AST_OVR_ON_SECOND: assert property (@(posedge clk) disable iff (!rst_n)
        rxc && frame_done && !buf_rd && !soft_clr |=> dor); // R6
endmodule

// File: rtl/sstat_wake.sv
module sstat_wake (
    input  logic clk,
    input  logic rst_n,
    input  logic uart_mode,
    input  logic stop_mode,
    input  logic rx_pin,
    input  logic clr_wr,
    output logic wake
);
    logic wake_set;

    always_comb wake_set = uart_mode && stop_mode && !rx_pin;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        wake <= 1'b0;
        else if (wake_set) wake <= 1'b1;
        else if (clr_wr)   wake <= 1'b0;
    end

    AST_WAKE_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        uart_mode && stop_mode && !rx_pin |=> wake); // R7
    AST_WAKE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        wake && !clr_wr |=> wake); // R7
    AST_WAKE_NO_ASYNC_SET: assert property (@(posedge clk) disable iff (!rst_n)
        !wake && !uart_mode |=> !wake); // R7
endmodule

// File: rtl/sstat_reg.sv
module sstat_reg
    import sstat_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              uart_mode,
    input  logic              par_en,
    input  logic              stop_mode,
    input  logic              rx_pin,
    input  logic              tx_buf_wr,
    input  logic              tx_buf_take,
    input  logic              tx_shift_done,
    input  logic              txc_ack,
    input  logic              rx_frame_done,
    input  logic              rx_frame_fe,
    input  logic              rx_frame_pe,
    input  logic              rx_buf_rd,
    input  logic              cpu_wr,
    input  logic [STAT_W-1:0] cpu_wdata,
    input  logic              ie_dre,
    input  logic              ie_txc,
    input  logic              ie_rxc,
    input  logic              ie_wake,
    output logic [STAT_W-1:0] stat_o,
    output logic              srst_o,
    output logic              irq_dre,
    output logic              irq_txc,
    output logic              irq_rxc,
    output logic              irq_wake
);
    lr_state_e lr_q, lr_d;
    logic dre, txc, rxc, dor, fe, pe, wake;
    logic wake_clr;
    logic unused_wbits;

    assign unused_wbits = ^{cpu_wdata[B_DRE:B_RXC], cpu_wdata[B_DOR:B_PE]};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lr_q <= LR_IDLE;
        else        lr_q <= lr_d;
    end

    always_comb begin
        lr_d = lr_q;
        unique case (lr_q)
            LR_IDLE:  if (cpu_wr && cpu_wdata[B_LRST]) lr_d = LR_PULSE;
            LR_PULSE: lr_d = LR_IDLE;
            default:  lr_d = LR_IDLE;
        endcase
    end

    always_comb begin
        srst_o   = (lr_q == LR_PULSE);
        wake_clr = cpu_wr && !cpu_wdata[B_WAKE];
    end

    sstat_tx u_tx (
        .clk        (clk),
        .rst_n      (rst_n),
        .soft_clr   (srst_o),
        .buf_wr     (tx_buf_wr),
        .buf_take   (tx_buf_take),
        .shift_done (tx_shift_done),
        .txc_ack    (txc_ack),
        .dre        (dre),
        .txc        (txc)
    );

    sstat_rx u_rx (
        .clk        (clk),
        .rst_n      (rst_n),
        .soft_clr   (srst_o),
        .uart_mode  (uart_mode),
        .par_en     (par_en),
        .frame_done (rx_frame_done),
        .frame_fe   (rx_frame_fe),
        .frame_pe   (rx_frame_pe),
        .buf_rd     (rx_buf_rd),
        .rxc        (rxc),
        .dor        (dor),
        .fe         (fe),
        .pe         (pe)
    );

    sstat_wake u_wake (
        .clk       (clk),
        .rst_n     (rst_n),
        .uart_mode (uart_mode),
        .stop_mode (stop_mode),
        .rx_pin    (rx_pin),
        .clr_wr    (wake_clr),
        .wake      (wake)
    );

    always_comb begin
        stat_o         = '0;
        stat_o[B_DRE]  = dre;
        stat_o[B_TXC]  = txc;
        stat_o[B_RXC]  = rxc;
        stat_o[B_WAKE] = wake;
        stat_o[B_LRST] = srst_o;
        stat_o[B_DOR]  = dor;
        stat_o[B_FE]   = fe;
        stat_o[B_PE]   = pe;
        irq_dre  = dre  && ie_dre;
        irq_txc  = txc  && ie_txc;
        irq_rxc  = rxc  && ie_rxc;
        irq_wake = wake && ie_wake;
    end

    AST_LR_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        srst_o |=> !srst_o); // R8
    AST_LR_RESTORES: assert property (@(posedge clk) disable iff (!rst_n)
        srst_o |=> ((stat_o & ~WAKE_MASK) == STAT_RST)); // R8
    AST_WR_KEEPS_RXC: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_wr && !rx_frame_done && !rx_buf_rd && !srst_o |=> $stable(stat_o[B_RXC])); // R9
endmodule

// File: tb/sstat_reg_tb.sv
module sstat_reg_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       uart_mode = 1'b1, par_en = 1'b0, stop_mode = 1'b0, rx_pin = 1'b1;
    logic       tx_buf_wr = 1'b0, tx_buf_take = 1'b0, tx_shift_done = 1'b0, txc_ack = 1'b0;
    logic       rx_frame_done = 1'b0, rx_frame_fe = 1'b0, rx_frame_pe = 1'b0, rx_buf_rd = 1'b0;
    logic       cpu_wr = 1'b0;
    logic [7:0] cpu_wdata = 8'h00;
    logic       ie_dre = 1'b0, ie_txc = 1'b0, ie_rxc = 1'b0, ie_wake = 1'b0;
    logic [7:0] stat_o;
    logic       srst_o, irq_dre, irq_txc, irq_rxc, irq_wake;
    int         total = 0;
    int         bad = 0;
    bit         done = 1'b0;

    always #10 clk = ~clk;

    sstat_reg u_dut (
        .clk(clk), .rst_n(rst_n), .uart_mode(uart_mode), .par_en(par_en),
        .stop_mode(stop_mode), .rx_pin(rx_pin), .tx_buf_wr(tx_buf_wr),
        .tx_buf_take(tx_buf_take), .tx_shift_done(tx_shift_done), .txc_ack(txc_ack),
        .rx_frame_done(rx_frame_done), .rx_frame_fe(rx_frame_fe), .rx_frame_pe(rx_frame_pe),
        .rx_buf_rd(rx_buf_rd), .cpu_wr(cpu_wr), .cpu_wdata(cpu_wdata),
        .ie_dre(ie_dre), .ie_txc(ie_txc), .ie_rxc(ie_rxc), .ie_wake(ie_wake),
        .stat_o(stat_o), .srst_o(srst_o), .irq_dre(irq_dre), .irq_txc(irq_txc),
        .irq_rxc(irq_rxc), .irq_wake(irq_wake)
    );

    task automatic step();
        @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic frame(input logic f, input logic p);
        rx_frame_done = 1'b1; rx_frame_fe = f; rx_frame_pe = p;
        step();
        rx_frame_done = 1'b0; rx_frame_fe = 1'b0; rx_frame_pe = 1'b0;
    endtask

    task automatic rd();
        rx_buf_rd = 1'b1; step(); rx_buf_rd = 1'b0;
    endtask

    task automatic wr(input logic [7:0] v);
        cpu_wr = 1'b1; cpu_wdata = v; step(); cpu_wr = 1'b0; cpu_wdata = 8'h00;
    endtask

    task automatic t_reset();
        ie_dre = 1'b1; ie_txc = 1'b1; ie_rxc = 1'b1; ie_wake = 1'b1;
        #1;
        chk("R1 status after reset", stat_o, 8'h80);
        chk("R1 srst_o after reset", {7'd0, srst_o}, 8'h00);
        chk("R10 irqs after reset", {4'd0, irq_dre, irq_txc, irq_rxc, irq_wake}, 8'h08);
        ie_dre = 1'b0; ie_txc = 1'b0; ie_rxc = 1'b0; ie_wake = 1'b0;
    endtask

    task automatic t_tx();
        ie_dre = 1'b1;
        tx_buf_wr = 1'b1; step(); tx_buf_wr = 1'b0;
        chk("R2 dre low after write", stat_o, 8'h00);
        chk("R10 irq_dre low", {7'd0, irq_dre}, 8'h00);
        tx_buf_take = 1'b1; step(); tx_buf_take = 1'b0;
        chk("R2 dre high after take", stat_o, 8'h80);
        chk("R10 irq_dre high", {7'd0, irq_dre}, 8'h01);
        ie_dre = 1'b0; #1;
        chk("R10 irq_dre gated", {7'd0, irq_dre}, 8'h00);
        tx_shift_done = 1'b1; step(); tx_shift_done = 1'b0;
        chk("R3 txc set when empty", stat_o, 8'hC0);
        ie_txc = 1'b1; #1;
        chk("R10 irq_txc", {7'd0, irq_txc}, 8'h01);
        txc_ack = 1'b1; step(); txc_ack = 1'b0;
        chk("R3 txc cleared by ack", stat_o, 8'h80);
        tx_shift_done = 1'b1; txc_ack = 1'b1; step(); tx_shift_done = 1'b0; txc_ack = 1'b0;
        chk("R3 set wins over ack", stat_o, 8'hC0);
        txc_ack = 1'b1; step(); txc_ack = 1'b0;
        chk("R3 ack clears again", stat_o, 8'h80);
        tx_buf_wr = 1'b1; step(); tx_buf_wr = 1'b0;
        tx_shift_done = 1'b1; step(); tx_shift_done = 1'b0;
        chk("R3 no set while buffer full", stat_o, 8'h00);
        tx_buf_take = 1'b1; step(); tx_buf_take = 1'b0;
        chk("R2 empty again", stat_o, 8'h80);
        ie_txc = 1'b0;
    endtask

    task automatic t_rx();
        par_en = 1'b0; ie_rxc = 1'b1;
        frame(1'b1, 1'b1);
        chk("R4 R5 first frame fe only", stat_o, 8'hA2);
        chk("R10 irq_rxc", {7'd0, irq_rxc}, 8'h01);
        frame(1'b0, 1'b0);
        chk("R6 overrun keeps fe", stat_o, 8'hA6);
        par_en = 1'b1;
        frame(1'b0, 1'b1);
        chk("R6 frame ignored in overrun", stat_o, 8'hA6);
        rd();
        chk("R4 R6 read clears all", stat_o, 8'h80);
        chk("R10 irq_rxc low", {7'd0, irq_rxc}, 8'h00);
        frame(1'b0, 1'b1);
        chk("R5 parity flagged", stat_o, 8'hA1);
        rx_buf_rd = 1'b1; frame(1'b1, 1'b0); rx_buf_rd = 1'b0;
        chk("R4 read with frame reloads", stat_o, 8'hA2);
        rd();
        chk("R4 read empties", stat_o, 8'h80);
        uart_mode = 1'b0;
        frame(1'b1, 1'b1);
        chk("R5 errors masked outside uart", stat_o, 8'hA0);
        rd();
        uart_mode = 1'b1; par_en = 1'b0; ie_rxc = 1'b0;
    endtask

    task automatic t_wake();
        ie_wake = 1'b1;
        stop_mode = 1'b1; rx_pin = 1'b0; step(); stop_mode = 1'b0; rx_pin = 1'b1;
        chk("R7 wake set", stat_o, 8'h90);
        chk("R10 irq_wake", {7'd0, irq_wake}, 8'h01);
        repeat (3) step();
        chk("R7 wake sticky", stat_o, 8'h90);
        wr(8'hF7);
        chk("R7 R9 write ones no effect", stat_o, 8'h90);
        stop_mode = 1'b1; rx_pin = 1'b0; wr(8'h00); stop_mode = 1'b0; rx_pin = 1'b1;
        chk("R7 set wins over clear", stat_o, 8'h90);
        wr(8'h00);
        chk("R7 write zero clears", stat_o, 8'h80);
        chk("R10 irq_wake low", {7'd0, irq_wake}, 8'h00);
        uart_mode = 1'b0; stop_mode = 1'b1; rx_pin = 1'b0; step();
        stop_mode = 1'b0; rx_pin = 1'b1; uart_mode = 1'b1;
        chk("R7 no wake outside uart", stat_o, 8'h80);
        ie_wake = 1'b0;
    endtask

    task automatic t_ignored();
        frame(1'b1, 1'b0);
        tx_shift_done = 1'b1; step(); tx_shift_done = 1'b0;
        chk("R9 setup", stat_o, 8'hE2);
        wr(8'h10);
        chk("R9 zero write ignored", stat_o, 8'hE2);
        wr(8'hE7);
        chk("R9 one write ignored", stat_o, 8'hE2);
        rd();
        txc_ack = 1'b1; step(); txc_ack = 1'b0;
        chk("R9 cleanup", stat_o, 8'h80);
    endtask

    task automatic t_lrst();
        tx_shift_done = 1'b1; step(); tx_shift_done = 1'b0;
        tx_buf_wr = 1'b1; step(); tx_buf_wr = 1'b0;
        frame(1'b1, 1'b1);
        frame(1'b0, 1'b0);
        stop_mode = 1'b1; rx_pin = 1'b0; step(); stop_mode = 1'b0; rx_pin = 1'b1;
        chk("R8 setup", stat_o, 8'h76);
        wr(8'h18);
        chk("R8 pulse visible", stat_o, 8'h7E);
        chk("R8 srst_o high", {7'd0, srst_o}, 8'h01);
        step();
        chk("R8 srst_o one cycle", {7'd0, srst_o}, 8'h00);
        chk("R8 flags restored, wake kept", stat_o, 8'h90);
        wr(8'h00);
        step();
        chk("R8 no second pulse", {srst_o, stat_o[6:0]}, 8'h00);
    endtask

    initial begin
        repeat (3) step();
        rst_n = 1'b1;
        step();
        t_reset();
        t_tx();
        t_rx();
        t_wake();
        t_ignored();
        t_lrst();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog R1 actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule